// File: doc/BRIEF.md
# NAND Flash Host Bus Sequencer

This block bridges a 32-bit request bus to an 8-bit asynchronous NAND flash device. The request offset decides what happens on the flash side. A write to the command window produces one command-latch byte cycle. A write to the address window produces one address-latch byte cycle. Any access to the data window moves a whole 32-bit word as four byte cycles, with the most significant byte first. Every byte cycle holds its write or read strobe low for a fixed number of clocks and then high for a fixed number of clocks. Both counts are parameters.

The same request bus also reaches a small set of plain registers:
- a control word that selects one of the chip-enable lines, or parks all of them;
- one enable word per bank;
- a status word that carries the synchronised ready/busy pin;
- a fixed revision word.

The chip enable is a static level set by these registers. It is not pulsed per access.

The request side uses a valid/ready handshake. The requester raises `req_valid` and holds `req_write`, `req_addr` and `req_wdata` stable until it sees `req_ready` high at a clock edge. That edge completes the transfer. For a read, `req_rdata` is valid in the same cycle that `req_ready` is high. A register access completes in the cycle it is presented. A flash access keeps `req_ready` low for as long as any of its byte cycles is still running. The flash data bus is modelled as separate output, output-enable and input vectors.

Top module: `nand_bus_seq`

## Requirements
- R1: A write to offset 0x00 performs exactly one byte cycle. In that cycle `req_wdata[7:0]` is driven on `nand_io_o` with `nand_io_oe` high, `nand_cle` high and `nand_ale` low while `nand_we_n` pulses.
- R2: A write to offset 0x04 performs exactly one byte cycle. In that cycle `req_wdata[7:0]` is driven with `nand_ale` high and `nand_cle` low.
- R3: A write to offset 0x08 performs four write byte cycles with both latch enables low. The bytes appear in the order bits 31:24, 23:16, 15:8, 7:0.
- R4: A read of offset 0x08 performs four `nand_re_n` pulses and no `nand_we_n` pulse, and `nand_io_oe` stays low throughout. Each pulse samples `nand_io_i` in its last low clock. The first byte sampled lands in bits 31:24 of `req_rdata`.
- R5: Each strobe is low for WP_CYCLES clocks and high for WH_CYCLES clocks between the bytes of one access. Write and read strobes are never low together, and both rest high when idle.
- R6: `req_ready` stays low while byte cycles are running. A flash access is acknowledged exactly 2 cycles after its last byte slot ends, that is nbytes*(WP_CYCLES+WH_CYCLES)+2 clock edges after it was accepted. A register access, or a read of offset 0x00 or 0x04, is acknowledged at once and causes no flash cycle.
- R7: In the control word at 0x40, bits 25:24 select the bank. When bank b is enabled and the park bit is clear, exactly `nand_ce_n[b]` is low. The word reads back bit 31 and bits 25:24, and all other bits read zero.
- R8: Control bit 31 (the park bit) drives every chip enable high, whatever the bank field holds. The park bit is 1 after reset.
- R9: The bank words at 0x30, 0x34, 0x38 and 0x3C carry an enable in bit 31. They reset to 0 and read back only bit 31. A selected bank whose enable is 0 gets no chip enable.
- R10: Status bit 24 at 0x44 follows `nand_rb_n` through a two-flop synchroniser. A change is not visible after one clock edge and is visible after two.
- R11: Offset 0x50 returns the REV_ID parameter, and writes to it have no effect. Reads of unmapped offsets return zero.
- R12: After reset all chip enables, `nand_we_n` and `nand_re_n` are high, and `nand_cle`, `nand_ale`, `nand_io_oe` and `req_ready` are low. `nand_io_oe` is high only during a write byte slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request completes at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, valid with req_ready |
| nand_ce_n | output | NBANK | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_o | output | 8 | Flash bus output byte |
| nand_io_oe | output | 1 | Flash bus output enable |
| nand_io_i | input | 8 | Flash bus input byte |
| nand_rb_n | input | 1 | Ready/busy pin, high = ready |

## Verification
Two functions can overlap in time: the ready/busy pin can change while a four-byte data read still holds the request bus. Status is not read during that time. The bench starts a data read and drops `nand_rb_n` partway through it. It then judges two things: the returned word must match the byte model, and the status read issued right after the acknowledge must already show busy. A separate step changes the pin at a known edge and checks that the status bit is still old after one edge and new after two.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {CYC_CMD, CYC_ADR, CYC_DWR, CYC_DRD} cyc_e;
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_e;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_ADR  = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_BANK = 8'h30;
  localparam logic [7:0] OFS_CTRL = 8'h40;
  localparam logic [7:0] OFS_STAT = 8'h44;
  localparam logic [7:0] OFS_REV  = 8'h50;

  localparam int BSEL_LSB  = 24;
  localparam int READY_BIT = 24;
endpackage

// File: rtl/nbs_sync.sv
module nbs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nbs_regs.sv
module nbs_regs
  import nbs_pkg::*;
#(
  parameter int          NBANK  = 4,
  parameter logic [31:0] REV_ID = 32'h0002_0601,
  localparam int         BS_W   = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       addr,
  input  logic             wd_msb,
  input  logic [BS_W-1:0]  wd_bsel,
  input  logic             ready_sync,
  output logic [31:0]      rdata,
  output logic [NBANK-1:0] ce_n
);
  logic            park_q;
  logic [BS_W-1:0] bsel_q;
  logic [NBANK-1:0] ben_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      park_q <= 1'b1;
      bsel_q <= '0;
    end else if (wr_en && addr == OFS_CTRL) begin
      park_q <= wd_msb;
      bsel_q <= wd_bsel;
    end
  end

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    localparam logic [7:0] BOFS = OFS_BANK + 8'(4 * i);

    always_ff @(posedge clk) begin
      if (!rst_n)                     ben_q[i] <= 1'b0;
      else if (wr_en && addr == BOFS) ben_q[i] <= wd_msb;
    end

    assign ce_n[i] = !(!park_q && ben_q[i] && bsel_q == BS_W'(i));

    // R9: a disabled bank never sees its chip enable asserted
    a_r9_disabled_bank_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ben_q[i] |-> ce_n[i]);
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_CTRL: begin
        rdata[31] = park_q;
        rdata[BSEL_LSB +: BS_W] = bsel_q;
      end
      OFS_STAT: rdata[READY_BIT] = ready_sync;
      OFS_REV:  rdata = REV_ID;
      default: begin
        for (int i = 0; i < NBANK; i++)
          if (addr == OFS_BANK + 8'(4 * i)) rdata[31] = ben_q[i];
      end
    endcase
  end

  a_r8_park_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    park_q |-> (&ce_n));
  a_r7_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ce_n));
endmodule

// File: rtl/nbs_engine.sv
module nbs_engine
  import nbs_pkg::*;
#(
  parameter int WP = 3,
  parameter int WH = 2,
  localparam int MAXC = (WP > WH) ? WP : WH,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  cyc_e        kind,
  input  logic [1:0]  nb_last,
  input  logic [31:0] wdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata,
  output logic        cle,
  output logic        ale,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  io_o,
  output logic        io_oe,
  input  logic [7:0]  io_i
);
  logic          busy_q, low_q, done_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    idx_q, last_q;
  cyc_e          kind_q;
  logic [31:0]   sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      low_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
      kind_q <= CYC_CMD;
      sh_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          low_q  <= 1'b1;
          cnt_q  <= '0;
          idx_q  <= '0;
          last_q <= nb_last;
          kind_q <= kind;
          sh_q   <= (kind == CYC_DWR) ? wdata : {wdata[7:0], 24'h0};
        end
      end else if (low_q) begin
        if (cnt_q == CW'(WP - 1)) begin
          low_q <= 1'b0;
          cnt_q <= '0;
          if (kind_q == CYC_DRD) sh_q <= {sh_q[23:0], io_i};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        if (cnt_q == CW'(WH - 1)) begin
          cnt_q <= '0;
          if (idx_q == last_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + 1'b1;
            low_q <= 1'b1;
            if (kind_q != CYC_DRD) sh_q <= {sh_q[23:0], 8'h00};
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy  = busy_q;
  assign done  = done_q;
  assign rdata = sh_q;
  assign cle   = busy_q && kind_q == CYC_CMD;
  assign ale   = busy_q && kind_q == CYC_ADR;
  assign io_oe = busy_q && kind_q != CYC_DRD;
  assign we_n  = !(busy_q && low_q && kind_q != CYC_DRD);
  assign re_n  = !(busy_q && low_q && kind_q == CYC_DRD);
  assign io_o  = io_oe ? sh_q[31:24] : 8'h00;

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  a_r5_idle_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (we_n && re_n && !io_oe));
  a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_oe |-> re_n);
  a_r1_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int          NBANK       = 4,
  parameter int          WP_CYCLES   = 3,
  parameter int          WH_CYCLES   = 2,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] REV_ID      = 32'h0002_0601,
  localparam int         BS_W        = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [7:0]       req_addr,
  input  logic [31:0]      req_wdata,
  output logic [31:0]      req_rdata,
  output logic [NBANK-1:0] nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [7:0]       nand_io_o,
  output logic             nand_io_oe,
  input  logic [7:0]       nand_io_i,
  input  logic             nand_rb_n
);
  st_e         st_q;
  logic        flash_go, reg_wr;
  cyc_e        go_kind;
  logic [1:0]  go_last;
  logic        eng_busy, eng_done, rb_sync;
  logic [31:0] eng_rdata, reg_rdata;

  always_comb begin
    flash_go = 1'b0;
    go_kind  = CYC_DRD;
    go_last  = 2'd0;
    if (req_addr == OFS_DATA) begin
      flash_go = 1'b1;
      go_kind  = req_write ? CYC_DWR : CYC_DRD;
      go_last  = 2'd3;
    end else if (req_write && req_addr == OFS_CMD) begin
      flash_go = 1'b1;
      go_kind  = CYC_CMD;
    end else if (req_write && req_addr == OFS_ADR) begin
      flash_go = 1'b1;
      go_kind  = CYC_ADR;
    end
  end

  wire idle_req = (st_q == S_IDLE) && req_valid;
  assign reg_wr = idle_req && !flash_go && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= S_IDLE;
    else begin
      case (st_q)
        S_IDLE:  if (idle_req && flash_go) st_q <= S_BUSY;
        S_BUSY:  if (eng_done) st_q <= S_DONE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == S_DONE) || (idle_req && !flash_go);
  assign req_rdata = (st_q == S_DONE) ? eng_rdata : reg_rdata;

  nbs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(nand_rb_n), .q(rb_sync)
  );

  nbs_regs #(.NBANK(NBANK), .REV_ID(REV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(req_addr),
    .wd_msb(req_wdata[31]), .wd_bsel(req_wdata[BSEL_LSB +: BS_W]),
    .ready_sync(rb_sync), .rdata(reg_rdata), .ce_n(nand_ce_n)
  );

  nbs_engine #(.WP(WP_CYCLES), .WH(WH_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(idle_req && flash_go), .kind(go_kind),
    .nb_last(go_last), .wdata(req_wdata), .busy(eng_busy), .done(eng_done),
    .rdata(eng_rdata), .cle(nand_cle), .ale(nand_ale), .we_n(nand_we_n),
    .re_n(nand_re_n), .io_o(nand_io_o), .io_oe(nand_io_oe), .io_i(nand_io_i)
  );

  a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !req_ready);
  a_r6_ack_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> req_ready);
endmodule

// File: tb/sim_nand_bus_seq.sv
module sim_nand_bus_seq;
  localparam int CLK_P = 10;
  localparam int WP = 3;
  localparam int WH = 2;
  localparam logic [31:0] REV = 32'h0002_0601;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready;
  logic [31:0] req_rdata;
  logic [3:0] nand_ce_n;
  logic nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0] nand_io_o, nand_io_i;
  logic nand_rb_n = 1'b1;
  logic [7:0] rd_k = '0, rd_seed = 8'h5A;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nand_bus_seq #(.NBANK(4), .WP_CYCLES(WP), .WH_CYCLES(WH), .REV_ID(REV)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rdata(req_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_io_o(nand_io_o), .nand_io_oe(nand_io_oe), .nand_io_i(nand_io_i),
    .nand_rb_n(nand_rb_n)
  );

  // flash byte model: a new byte per falling read strobe
  always @(negedge nand_re_n) rd_k = rd_k + 8'd1;
  assign nand_io_i = rd_seed ^ (rd_k * 8'h1D);

  function automatic logic [7:0] model_byte(input logic [7:0] seed, input logic [7:0] k);
    return seed ^ (k * 8'h1D);
  endfunction

  // pin monitor
  int we_run = 0, re_run = 0, hi_run = 0, nwe = 0, nre = 0, nstb = 0, oe_bad = 0;
  logic [7:0] wbyte [64];
  logic wcle [64], wale [64], woe [64];
  int wlow [64], rlow [64], gap [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_re_n && nand_io_oe) oe_bad++;
      if (!nand_we_n || !nand_re_n) begin
        if (we_run == 0 && re_run == 0) begin
          gap[nstb % 64] = hi_run;
          nstb++;
        end
        hi_run = 0;
      end else hi_run++;
      if (!nand_we_n) we_run++;
      else if (we_run > 0) begin
        wbyte[nwe % 64] = nand_io_o;
        wcle[nwe % 64] = nand_cle;
        wale[nwe % 64] = nand_ale;
        woe[nwe % 64] = nand_io_oe;
        wlow[nwe % 64] = we_run;
        nwe++;
        we_run = 0;
      end
      if (!nand_re_n) re_run++;
      else if (re_run > 0) begin
        rlow[nre % 64] = re_run;
        nre++;
        re_run = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int waits);
    waits = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready && waits < 1000) begin
      @(negedge clk); #1;
      waits++;
    end
    q = req_rdata;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] q, exp;
    int wt, bw, br, bs;
    logic [7:0] k0;
    logic [31:0] pats [6];

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 ce_n", {28'h0, nand_ce_n}, 32'hF);
    chk("R12 strobes", {30'h0, nand_we_n, nand_re_n}, 32'h3);
    chk("R12 cle/ale/oe/ready", {28'h0, nand_cle, nand_ale, nand_io_oe, req_ready}, 32'h0);
    bus(1'b0, 8'h40, 0, q, wt); chk("R8 park after reset", q, 32'h8000_0000);

    // R11 revision and unmapped
    bus(1'b0, 8'h50, 0, q, wt); chk("R11 rev", q, REV);
    bus(1'b1, 8'h50, 32'hFFFF_FFFF, q, wt);
    bus(1'b0, 8'h50, 0, q, wt); chk("R11 rev after write", q, REV);
    bus(1'b0, 8'h7C, 0, q, wt); chk("R11 unmapped", q, 32'h0);
    bw = nwe;
    bus(1'b0, 8'h00, 0, q, wt);
    chk("R6 cmd-window read immediate", wt, 0);
    chk("R6 cmd-window read no cycle", nwe - bw, 0);
    bus(1'b0, 8'h04, 0, q, wt); chk("R6 adr-window read data", q, 0);

    // R7/R8/R9 chip-enable sweep
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 4; i++) bus(1'b1, 8'h30 + 8'(4*i), {m[i], 31'h1234_5678}, q, wt);
      for (int i = 0; i < 4; i++) begin
        bus(1'b0, 8'h30 + 8'(4*i), 0, q, wt);
        chk("R9 bank readback", q, {m[i], 31'h0});
      end
      for (int p = 0; p < 2; p++) begin
        for (int b = 0; b < 4; b++) begin
          bus(1'b1, 8'h40, {p[0], 5'h1F, b[1:0], 24'hFFFFFF}, q, wt);
          chk("R6 reg write immediate", wt, 0);
          bus(1'b0, 8'h40, 0, q, wt);
          chk("R7 ctrl readback", q, {p[0], 5'h0, b[1:0], 24'h0});
          exp = (p != 0 || !m[b]) ? 32'hF : {28'h0, ~(4'b1 << b)};
          chk(p != 0 ? "R8 park" : (m[b] ? "R7 select" : "R9 disabled"), {28'h0, nand_ce_n}, exp);
        end
      end
    end
    for (int i = 0; i < 4; i++) bus(1'b1, 8'h30 + 8'(4*i), 32'h8000_0000, q, wt);
    bus(1'b1, 8'h40, 32'h0200_0000, q, wt);

    // R1 command cycles
    for (int c = 0; c < 5; c++) begin
      logic [7:0] cb;
      cb = (c == 0) ? 8'h00 : (c == 1) ? 8'h70 : (c == 2) ? 8'hFF : (c == 3) ? 8'h90 : 8'h30;
      bw = nwe; br = nre;
      bus(1'b1, 8'h00, {24'hABCDEF, cb}, q, wt);
      chk("R6 cmd ack latency", wt, WP + WH + 2);
      chk("R1 one byte", nwe - bw, 1);
      chk("R1 no read", nre - br, 0);
      chk("R1 byte", wbyte[bw % 64], cb);
      chk("R1 cle/ale/oe", {29'h0, wcle[bw % 64], wale[bw % 64], woe[bw % 64]}, 32'h5);
      chk("R5 we low width", wlow[bw % 64], WP);
    end

    // R2 address cycles
    for (int c = 0; c < 3; c++) begin
      logic [7:0] ab;
      ab = 8'h11 * 8'(c + 3);
      bw = nwe;
      bus(1'b1, 8'h04, {24'h55AA55, ab}, q, wt);
      chk("R2 one byte", nwe - bw, 1);
      chk("R2 byte", wbyte[bw % 64], ab);
      chk("R2 cle/ale", {30'h0, wcle[bw % 64], wale[bw % 64]}, 32'h1);
    end

    // R3 data writes
    pats[0] = 32'h1122_3344; pats[1] = 32'hDEAD_BEEF; pats[2] = 32'h00FF_00FF;
    pats[3] = 32'h8000_0001; pats[4] = 32'h0000_0000; pats[5] = 32'hA5C3_3C5A;
    for (int t = 0; t < 6; t++) begin
      bw = nwe; bs = nstb;
      bus(1'b1, 8'h08, pats[t], q, wt);
      chk("R6 data ack latency", wt, 4 * (WP + WH) + 2);
      chk("R3 four bytes", nwe - bw, 4);
      for (int j = 0; j < 4; j++) begin
        chk("R3 byte order", wbyte[(bw + j) % 64], pats[t][31 - 8*j -: 8]);
        chk("R3 latches low", {30'h0, wcle[(bw + j) % 64], wale[(bw + j) % 64]}, 0);
        chk("R5 low width", wlow[(bw + j) % 64], WP);
        if (j > 0) chk("R5 high width", gap[(bs + j) % 64], WH);
      end
    end

    // R4 data reads
    for (int t = 0; t < 5; t++) begin
      rd_seed = 8'h5A + 8'(t * 37);
      k0 = rd_k; bw = nwe; br = nre; bs = nstb;
      bus(1'b0, 8'h08, 0, q, wt);
      exp = {model_byte(rd_seed, k0 + 8'd1), model_byte(rd_seed, k0 + 8'd2),
             model_byte(rd_seed, k0 + 8'd3), model_byte(rd_seed, k0 + 8'd4)};
      chk("R4 read word", q, exp);
      chk("R4 four strobes", nre - br, 4);
      chk("R4 no write strobe", nwe - bw, 0);
      chk("R6 read ack latency", wt, 4 * (WP + WH) + 2);
      for (int j = 0; j < 4; j++) begin
        chk("R5 re low width", rlow[(br + j) % 64], WP);
        if (j > 0) chk("R5 re high width", gap[(bs + j) % 64], WH);
      end
    end
    chk("R4 oe low during reads", oe_bad, 0);

    // R10 sync latency
    bus(1'b0, 8'h44, 0, q, wt); chk("R10 ready high", q, 32'h0100_0000);
    @(negedge clk); nand_rb_n = 1'b0;
    bus(1'b0, 8'h44, 0, q, wt); chk("R10 old after one edge", q, 32'h0100_0000);
    bus(1'b0, 8'h44, 0, q, wt); chk("R10 new after two edges", q, 32'h0);
    @(negedge clk); nand_rb_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10 pin drop during a data read
    rd_seed = 8'hC7; k0 = rd_k;
    fork
      bus(1'b0, 8'h08, 0, q, wt);
      begin repeat (6) @(negedge clk); nand_rb_n = 1'b0; end
    join
    exp = {model_byte(8'hC7, k0 + 8'd1), model_byte(8'hC7, k0 + 8'd2),
           model_byte(8'hC7, k0 + 8'd3), model_byte(8'hC7, k0 + 8'd4)};
    chk("R4 word with busy edge", q, exp);
    bus(1'b0, 8'h44, 0, q, wt); chk("R10 busy after read", q, 32'h0);

    summary();
  end
endmodule